// File: doc/BRIEF.md
# Network Status LED Driver

This block turns live network line state and activity events into the drive levels for two indicator LEDs, called A and B. Each LED has a 4-bit mode taken from a 16-bit control word. The mode selects one of several behaviours:

- a fixed level;
- a free-running blink;
- a plain status level;
- an activity indication;
- a status level that dips briefly on activity.

A two-bit field chooses how long an activity event is held visible, and one bit enables that holding for the activity-only modes.

Short activity events are widened by hold counters so that they are visible to the eye. Three counters are shared by both LEDs: transmit, receive and collision. Every hold length and both blink half-periods are parameters in clock cycles. The control word is a plain input. The integrator keeps it in whatever register it likes, and the package provides a suggested power-up value, `CTRL_POWERUP`.

Top module: `netled_drv`

## Requirements
- R1: LED A takes its mode from `ctrl_word[11:8]` and LED B from `ctrl_word[7:4]`. `ctrl_word[3:2]` chooses the hold length and `ctrl_word[1]` is the hold enable. Bits 15:12 and bit 0 have no effect.
- R2: Mode 4'b1000 drives the LED constantly on, and mode 4'b1001 drives it constantly off.
- R3: Mode 4'b1010 blinks with a half-period of `FAST_HALF` cycles and mode 4'b1011 with a half-period of `SLOW_HALF` cycles. Both blinkers start in the off phase when reset is released, and each toggles after every half-period of non-reset clock edges.
- R4: Mode 4'b0100 follows `link_up` and mode 4'b0101 follows `full_dup`, with no hold applied.
- R5: The activity modes are 4'b0001 (transmit), 4'b0010 (receive), 4'b0011 (collision) and 4'b0111 (transmit or receive). With the hold enable at 0, these modes light the LED only in cycles where the selected event input is high.
- R6: With the hold enable at 1, an activity mode lights the LED while its event input is high and for N further cycles after the last cycle the event was high. N is `SHORT_CYC` for select 2'b00, `MED_CYC` for 2'b01, `LONG_CYC` for 2'b10 and `SHORT_CYC` for the reserved 2'b11. The length is the one selected in the event cycle.
- R7: An event that arrives while a hold is running restarts the full hold length from that event.
- R8: Mode 4'b1100 drives `link_up` AND NOT held receive activity. Mode 4'b1101 drives `link_up` AND NOT held transmit-or-receive activity. Mode 4'b1110 drives `full_dup` AND NOT held collision activity. These three modes always use held activity, whatever the hold enable says, and they stay off while their status input is low.
- R9: Codes 4'b0000, 4'b0110 and 4'b1111 are reserved and drive the LED off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 16 | Mode, hold select and hold enable fields |
| link_up | input | 1 | Live link status |
| full_dup | input | 1 | Live full-duplex status |
| tx_evt | input | 1 | Transmit activity event |
| rx_evt | input | 1 | Receive activity event |
| col_evt | input | 1 | Collision event |
| led_a | output | 1 | Drive level for LED A, high = lit |
| led_b | output | 1 | Drive level for LED B, high = lit |

## Verification
Two hold-counter functions can fall in the same cycle: a running hold reaching its last cycle, and a fresh event restarting it. In the combined modes, a status change can also coincide with the end of an activity dip.

The bench provokes both by sweeping every mode pair, hold select and enable setting while dense pseudo-random events and slowly toggling status inputs arrive. The hold lengths are set to a few cycles, so that restart-at-expiry happens often. Every cycle is judged against a count model built from the requirements, and a directed sequence pins the restart timing down explicitly.

// File: rtl/netled_pkg.sv
package netled_pkg;

    typedef enum logic [3:0] {
        M_RSV0     = 4'b0000,
        M_TX       = 4'b0001,
        M_RX       = 4'b0010,
        M_COL      = 4'b0011,
        M_LINK     = 4'b0100,
        M_DUP      = 4'b0101,
        M_RSV6     = 4'b0110,
        M_TXRX     = 4'b0111,
        M_ON       = 4'b1000,
        M_OFF      = 4'b1001,
        M_FAST     = 4'b1010,
        M_SLOW     = 4'b1011,
        M_LINK_RX  = 4'b1100,
        M_LINK_TRX = 4'b1101,
        M_DUP_COL  = 4'b1110,
        M_RSV15    = 4'b1111
    } led_mode_e;

    typedef enum logic [1:0] {
        HOLD_SHORT = 2'b00,
        HOLD_MED   = 2'b01,
        HOLD_LONG  = 2'b10,
        HOLD_RSV   = 2'b11
    } hold_sel_e;

    typedef struct packed {
        led_mode_e mode_a;
        led_mode_e mode_b;
        hold_sel_e sel;
        logic      hold_en;
    } ctrl_view_t;

    typedef struct packed {
        logic link;
        logic duplex;
    } line_state_t;

    typedef struct packed {
        logic tx;
        logic rx;
        logic col;
    } activity_t;

    localparam int NUM_LEDS = 2;
    localparam int NUM_SRC  = 3;

    // Suggested power-up control: A = link + tx/rx (held), B = rx activity,
    // hold enabled at the short length.
    localparam logic [15:0] CTRL_POWERUP = 16'h3D22;

    function automatic ctrl_view_t unpack_ctrl(input logic [15:0] w);
        ctrl_view_t v;
        v.mode_a  = led_mode_e'(w[11:8]);
        v.mode_b  = led_mode_e'(w[7:4]);
        v.sel     = hold_sel_e'(w[3:2]);
        v.hold_en = w[1];
        return v;
    endfunction

    function automatic logic is_reserved(input led_mode_e m);
        return (m == M_RSV0) || (m == M_RSV6) || (m == M_RSV15);
    endfunction

    function automatic logic is_combined(input led_mode_e m);
        return (m == M_LINK_RX) || (m == M_LINK_TRX) || (m == M_DUP_COL);
    endfunction

endpackage

// File: rtl/netled_hold.sv
module netled_hold #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt_i,
    input  logic [CW-1:0] len_i,
    output logic          act_o
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (evt_i) begin
            cnt <= len_i;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign act_o = evt_i | (cnt != '0);

    // An event with a non-zero length keeps the output lit on the next cycle.
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_i && len_i != '0) |=> act_o);

    // A hold can only end on a cycle that followed a quiet cycle.
    assert_hold_end_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(act_o) |-> !$past(evt_i));

endmodule

// File: rtl/netled_blink.sv
module netled_blink #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    output logic phase_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            phase_o <= 1'b0;
        end else if (cnt == LAST) begin
            cnt     <= '0;
            phase_o <= ~phase_o;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_toggle_at_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_o != $past(phase_o)) |-> ($past(cnt) == LAST));

endmodule

// File: rtl/netled_pick.sv
module netled_pick
    import netled_pkg::*;
(
    input  led_mode_e   mode_i,
    input  logic        hold_en_i,
    input  line_state_t line_i,
    input  activity_t   raw_i,
    input  activity_t   held_i,
    input  logic        fast_i,
    input  logic        slow_i,
    output logic        led_o
);
    activity_t act;

    // Activity-only modes use the held view only when holding is enabled.
    assign act = hold_en_i ? held_i : raw_i;

    always_comb begin
        unique case (mode_i)
            M_ON:       led_o = 1'b1;
            M_OFF:      led_o = 1'b0;
            M_FAST:     led_o = fast_i;
            M_SLOW:     led_o = slow_i;
            M_LINK:     led_o = line_i.link;
            M_DUP:      led_o = line_i.duplex;
            M_TX:       led_o = act.tx;
            M_RX:       led_o = act.rx;
            M_COL:      led_o = act.col;
            M_TXRX:     led_o = act.tx | act.rx;
            M_LINK_RX:  led_o = line_i.link & ~held_i.rx;
            M_LINK_TRX: led_o = line_i.link & ~(held_i.tx | held_i.rx);
            M_DUP_COL:  led_o = line_i.duplex & ~held_i.col;
            default:    led_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/netled_drv.sv
module netled_drv
    import netled_pkg::*;
#(
    parameter int SHORT_CYC = 1_000_000,
    parameter int MED_CYC   = 2_000_000,
    parameter int LONG_CYC  = 3_500_000,
    parameter int FAST_HALF = 2_500_000,
    parameter int SLOW_HALF = 6_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] ctrl_word,
    input  logic        link_up,
    input  logic        full_dup,
    input  logic        tx_evt,
    input  logic        rx_evt,
    input  logic        col_evt,
    output logic        led_a,
    output logic        led_b
);
    localparam int MAXC_SM = (SHORT_CYC > MED_CYC) ? SHORT_CYC : MED_CYC;
    localparam int MAXC    = (MAXC_SM > LONG_CYC) ? MAXC_SM : LONG_CYC;
    localparam int CW      = $clog2(MAXC + 1);

    ctrl_view_t    cfg;
    line_state_t   line_s;
    activity_t     raw_s;
    activity_t     held_s;
    logic [NUM_SRC-1:0] raw_vec;
    logic [NUM_SRC-1:0] held_vec;
    logic [CW-1:0] hold_len;
    logic          fast_ph;
    logic          slow_ph;
    led_mode_e     mode_v [NUM_LEDS];
    logic [NUM_LEDS-1:0] led_v;
    logic          unused_ctrl;

    assign cfg         = unpack_ctrl(ctrl_word);
    assign unused_ctrl = ^{ctrl_word[15:12], ctrl_word[0]};
    assign line_s      = '{link: link_up, duplex: full_dup};
    assign raw_s       = '{tx: tx_evt, rx: rx_evt, col: col_evt};
    assign raw_vec     = raw_s;
    assign held_s      = activity_t'(held_vec);

    always_comb begin
        unique case (cfg.sel)
            HOLD_MED:  hold_len = CW'(MED_CYC);
            HOLD_LONG: hold_len = CW'(LONG_CYC);
            default:   hold_len = CW'(SHORT_CYC);
        endcase
    end

    for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_hold
        netled_hold #(.CW(CW)) hold_i (
            .clk   (clk),
            .rst   (rst),
            .evt_i (raw_vec[gs]),
            .len_i (hold_len),
            .act_o (held_vec[gs])
        );
    end

    netled_blink #(.HALF(FAST_HALF)) fast_i (
        .clk     (clk),
        .rst     (rst),
        .phase_o (fast_ph)
    );

    netled_blink #(.HALF(SLOW_HALF)) slow_i (
        .clk     (clk),
        .rst     (rst),
        .phase_o (slow_ph)
    );

    assign mode_v[0] = cfg.mode_a;
    assign mode_v[1] = cfg.mode_b;

    for (genvar gl = 0; gl < NUM_LEDS; gl++) begin : g_led
        netled_pick pick_i (
            .mode_i    (mode_v[gl]),
            .hold_en_i (cfg.hold_en),
            .line_i    (line_s),
            .raw_i     (raw_s),
            .held_i    (held_s),
            .fast_i    (fast_ph),
            .slow_i    (slow_ph),
            .led_o     (led_v[gl])
        );

        assert_forced_R2: assert property (@(posedge clk) disable iff (rst)
            (mode_v[gl] == M_ON) |-> led_v[gl]);

        assert_reserved_off_R9: assert property (@(posedge clk) disable iff (rst)
            is_reserved(mode_v[gl]) |-> !led_v[gl]);

        assert_combined_dark_R8: assert property (@(posedge clk) disable iff (rst)
            (is_combined(mode_v[gl]) &&
             !((mode_v[gl] == M_DUP_COL) ? full_dup : link_up)) |-> !led_v[gl]);
    end

    assign led_a = led_v[0];
    assign led_b = led_v[1];

endmodule

// File: tb/netled_drv_tb_top.sv
`timescale 1ns/1ps
module netled_drv_tb_top;
    import netled_pkg::*;

    localparam int SH = 3;
    localparam int MD = 6;
    localparam int LG = 11;
    localparam int FH = 4;
    localparam int SL = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ctrl = CTRL_POWERUP;
    logic        link = 1'b0, dup = 1'b0, tx = 1'b0, rx = 1'b0, col = 1'b0;
    logic        led_a, led_b;

    always #10 clk = ~clk;

    netled_drv #(
        .SHORT_CYC(SH), .MED_CYC(MD), .LONG_CYC(LG),
        .FAST_HALF(FH), .SLOW_HALF(SL)
    ) dut_i (
        .clk(clk), .rst(rst), .ctrl_word(ctrl),
        .link_up(link), .full_dup(dup),
        .tx_evt(tx), .rx_evt(rx), .col_evt(col),
        .led_a(led_a), .led_b(led_b)
    );

    int n_chk = 0;
    int n_bad = 0;
    int c_tx = 0, c_rx = 0, c_col = 0, bm = 0;
    logic [15:0] lf = 16'hACE1;

    function automatic int len_of(input logic [1:0] s);
        case (s)
            2'b01:   return MD;
            2'b10:   return LG;
            default: return SH;
        endcase
    endfunction

    // Reference counts per event source and edges since reset.
    always @(posedge clk) begin
        if (rst) begin
            c_tx <= 0; c_rx <= 0; c_col <= 0; bm <= 0;
        end else begin
            c_tx  <= tx  ? len_of(ctrl[3:2]) : (c_tx  > 0 ? c_tx  - 1 : 0);
            c_rx  <= rx  ? len_of(ctrl[3:2]) : (c_rx  > 0 ? c_rx  - 1 : 0);
            c_col <= col ? len_of(ctrl[3:2]) : (c_col > 0 ? c_col - 1 : 0);
            bm    <= bm + 1;
        end
    end

    function automatic logic expect_led(input logic [3:0] m);
        logic ht, hr, hc, en, at, ar, ac;
        ht = tx  || (c_tx  > 0);
        hr = rx  || (c_rx  > 0);
        hc = col || (c_col > 0);
        en = ctrl[1];
        at = en ? ht : tx;
        ar = en ? hr : rx;
        ac = en ? hc : col;
        case (m)
            4'b1000: return 1'b1;
            4'b1001: return 1'b0;
            4'b1010: return ((bm / FH) % 2) == 1;
            4'b1011: return ((bm / SL) % 2) == 1;
            4'b0100: return link;
            4'b0101: return dup;
            4'b0001: return at;
            4'b0010: return ar;
            4'b0011: return ac;
            4'b0111: return at | ar;
            4'b1100: return link & ~hr;
            4'b1101: return link & ~(ht | hr);
            4'b1110: return dup & ~hc;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] m, input logic en);
        case (m)
            4'b1000, 4'b1001:                   return "R2";
            4'b1010, 4'b1011:                   return "R3";
            4'b0100, 4'b0101:                   return "R4";
            4'b0001, 4'b0010, 4'b0011, 4'b0111: return en ? "R6" : "R5";
            4'b1100, 4'b1101, 4'b1110:          return "R8";
            default:                            return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b (mode A=%b B=%b sel=%b en=%b t=%0t)",
                     tag, what, act, exp, ctrl[11:8], ctrl[7:4], ctrl[3:2], ctrl[1], $time);
        end
    endtask

    task automatic check_both();
        check(tag_of(ctrl[11:8], ctrl[1]), "led_a", led_a, expect_led(ctrl[11:8]));
        check(tag_of(ctrl[7:4],  ctrl[1]), "led_b", led_b, expect_led(ctrl[7:4]));
    endtask

    task automatic rand_cycle();
        @(negedge clk);
        lf   = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        tx   = (lf[2:0]  == 3'd0);
        rx   = (lf[5:3]  == 3'd1);
        col  = (lf[8:6]  == 3'd2);
        if (lf[15:12] == 4'd5) link = ~link;
        if (lf[11:8]  == 4'd9) dup  = ~dup;
        #8;
        check_both();
    endtask

    task automatic quiet_cycle(input logic t);
        @(negedge clk);
        tx = t; rx = 1'b0; col = 1'b0;
        #8;
    endtask

    initial begin
        #(20 * 100_000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #8;
        // Power-up control, all inputs low: both LEDs dark.
        check("R8", "reset led_a", led_a, 1'b0);
        check("R6", "reset led_b", led_b, 1'b0);

        // R1: field positions, with the unused bits set to confuse.
        @(negedge clk);
        ctrl = {4'b1111, 4'b1000, 4'b1001, 2'b00, 1'b0, 1'b1};
        #8;
        check("R1", "A from bits 11:8", led_a, 1'b1);
        check("R1", "B from bits 7:4",  led_b, 1'b0);
        @(negedge clk);
        ctrl = {4'b0000, 4'b1001, 4'b1000, 2'b00, 1'b0, 1'b0};
        #8;
        check("R1", "A from bits 11:8", led_a, 1'b0);
        check("R1", "B from bits 7:4",  led_b, 1'b1);

        // R7: restart of a running hold, short length, transmit mode on A.
        @(negedge clk);
        ctrl = {4'b0000, 4'b0001, 4'b1001, 2'b00, 1'b1, 1'b0};
        repeat (LG + 2) quiet_cycle(1'b0);
        quiet_cycle(1'b1);
        check("R7", "first pulse", led_a, 1'b1);
        for (int i = 1; i <= 2; i++) begin
            quiet_cycle(1'b0);
            check("R7", "between pulses", led_a, 1'b1);
        end
        quiet_cycle(1'b1);
        check("R7", "second pulse", led_a, 1'b1);
        for (int i = 1; i <= SH + 1; i++) begin
            quiet_cycle(1'b0);
            check("R7", "after restart", led_a, (i <= SH) ? 1'b1 : 1'b0);
        end

        // Sweep: every mode on A with its complement on B, all selects and enables.
        for (int ma = 0; ma < 16; ma++) begin
            for (int en = 0; en < 2; en++) begin
                for (int sel = 0; sel < 4; sel++) begin
                    @(negedge clk);
                    ctrl = {2'b00, 2'b11, 4'(ma), 4'(15 - ma), 2'(sel), 1'(en), 1'b0};
                    #8;
                    check_both();
                    repeat (30) rand_cycle();
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule